// File: doc/BRIEF.md
# Synchronous Clock Stop Gate

This block stops and restarts a group of clock outputs while the generator that feeds them keeps running. A free-running divider makes a shared output phase from the source clock. Each output lane follows that phase unless it is marked stoppable and the active-low halt request is asserted. A stopped lane parks at a fixed level. Differential lanes park with the true leg high and the complement leg low. Single-ended lanes park low.

The halt request passes through a two-flop synchronizer. Lanes enter and leave the parked state only on a phase edge where the next running level equals the parked level. Because of this, the true leg never shows a pulse shorter than a running half period. On restart a lane rejoins the shared phase, so a resumed output stays aligned with the outputs that never stopped. The stoppable mask is looked at only on those safe edges. A mask change during a halt therefore takes effect at the next safe boundary of the affected lane.

Top module: `clkstop_gate`

## Requirements
- R1: While `rst_n` is low, every `clk_t` bit is 0. Each `clk_c` bit equals the matching `DIFF_MAP` bit, so it is 1 for differential lanes and 0 for single-ended lanes.
- R2: A running lane's `clk_t` follows the shared phase. After reset release that phase is floor(n/HALF) mod 2, where n counts rising `clk` edges since release. On a differential lane (`DIFF_MAP` bit 1), `clk_c` is always the inverse of `clk_t`.
- R3: A lane whose `stoppable` bit is 0 keeps running whatever the level of `halt_req_n`.
- R4: A stopped differential lane holds `clk_t`=1 and `clk_c`=0.
- R5: A stopped single-ended lane (`DIFF_MAP` bit 0) holds `clk_t`=0. On single-ended lanes `clk_c` is 0 at all times.
- R6: Every high interval and every low interval of each `clk_t` bit lasts at least HALF `clk` cycles, including across stop and restart.
- R7: Suppose `halt_req_n` is low and the lane's `stoppable` bit is 1, and both inputs have been stable for 2*HALF+2 rising edges. Then the lane is parked.
- R8: Suppose `halt_req_n` is high, or the lane's `stoppable` bit is 0, and both inputs have been stable for 2*HALF+2 rising edges. Then the lane is running and aligned with the shared phase. A restart therefore completes within two output periods.
- R9: If the `stoppable` mask changes while `halt_req_n` stays low, each lane starts or stops at its own next safe boundary, within the bound of R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low reset |
| halt_req_n | input | 1 | Active-low request to stop the stoppable lanes (asynchronous) |
| stoppable | input | N_OUT | Per-lane mask, 1 = lane reacts to the halt request |
| clk_t | output | N_OUT | True-leg clock level per lane |
| clk_c | output | N_OUT | Complement-leg level per lane (0 for single-ended lanes) |

## Verification
The bench builds the gate with N_OUT=4, HALF=2 and DIFF_MAP=4'b0011, which gives two differential lanes and two single-ended lanes. It sweeps all 16 mask values. For each mask it asserts the halt request at each of the four offsets within an output period, so every lane type meets both the stop boundary and the restart boundary at every phase position. A second sweep changes the mask while the halt is held. This exercises staggered release and capture of individual lanes against the shared phase that the bench computes from its own edge count.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  // Level a lane parks at: differential lanes park with the true leg high.
  function automatic logic park_level(input logic is_diff);
    return is_diff;
  endfunction

  // A transition into or out of the parked state is safe only when the
  // next running level equals the parked level.
  function automatic logic safe_edge(input logic next_lvl, input logic park);
    return next_lvl == park;
  endfunction
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic stop_req
);
  logic s1_q, s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= async_n;
      s2_q <= s1_q;
    end
  end
  assign stop_req = ~s2_q;
endmodule

// File: rtl/clkstop_phase.sv
module clkstop_phase #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase,
  output logic phase_edge
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt_q;

  assign phase_edge = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (phase_edge) begin
      cnt_q <= '0;
      phase <= ~phase;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/clkstop_lane.sv
module clkstop_lane
  import clkstop_pkg::*;
#(
  parameter bit IS_DIFF = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  input  logic phase_edge,
  input  logic want_stop,
  output logic parked,
  output logic out_t,
  output logic out_c
);
  localparam logic PARK = park_level(IS_DIFF);
  logic nxt;
  logic safe;

  assign nxt  = ~phase;
  assign safe = safe_edge(nxt, PARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parked <= 1'b0;
      out_t  <= 1'b0;
    end else if (phase_edge) begin
      if (parked) begin
        if (!want_stop && safe) begin
          parked <= 1'b0;
          out_t  <= nxt;
        end
      end else begin
        out_t <= nxt;
        if (want_stop && safe) parked <= 1'b1;
      end
    end
  end

  generate
    if (IS_DIFF) begin : g_diff
      assign out_c = ~out_t;
    end else begin : g_se
      assign out_c = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int             N_OUT    = 4,
  parameter int             HALF     = 2,
  parameter logic [N_OUT-1:0] DIFF_MAP = 4'b0011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req_n,
  input  logic [N_OUT-1:0] stoppable,
  output logic [N_OUT-1:0] clk_t,
  output logic [N_OUT-1:0] clk_c
);
  logic             stop_req;
  logic             phase;
  logic             phase_edge;
  logic [N_OUT-1:0] parked;

  clkstop_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_n  (halt_req_n),
    .stop_req (stop_req)
  );

  clkstop_phase #(.HALF(HALF)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .phase_edge (phase_edge)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    clkstop_lane #(.IS_DIFF(DIFF_MAP[i])) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .phase_edge (phase_edge),
      .want_stop  (stop_req & stoppable[i]),
      .parked     (parked[i]),
      .out_t      (clk_t[i]),
      .out_c      (clk_c[i])
    );
  end
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
  parameter int             N_OUT    = 4,
  parameter int             HALF     = 2,
  parameter logic [N_OUT-1:0] DIFF_MAP = 4'b0011
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic             phase,
  input logic             phase_edge,
  input logic [N_OUT-1:0] stoppable,
  input logic [N_OUT-1:0] parked,
  input logic [N_OUT-1:0] clk_t
);
  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_edge |=> (phase != $past(phase)));

  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    // R6
    edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_t[i] != $past(clk_t[i])) |-> $past(phase_edge));
    // R4
    park_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      parked[i] |-> (clk_t[i] == DIFF_MAP[i]));
    // R3
    stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(parked[i]) |-> $past(stop_req && stoppable[i]));
    // R8
    run_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !parked[i] |-> (clk_t[i] == phase));
  end
endmodule

bind clkstop_gate clkstop_chk #(.N_OUT(N_OUT), .HALF(HALF), .DIFF_MAP(DIFF_MAP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_req   (stop_req),
  .phase      (phase),
  .phase_edge (phase_edge),
  .stoppable  (stoppable),
  .parked     (parked),
  .clk_t      (clk_t)
);

// File: tb/sim_clkstop_gate.sv
`timescale 1ns/1ps
module sim_clkstop_gate;
  localparam int         N    = 4;
  localparam int         HALF = 2;
  localparam logic [3:0] DMAP = 4'b0011;
  localparam int         LAT  = 2 * HALF + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         halt_req_n = 1'b1;
  logic [N-1:0] stoppable = '0;
  logic [N-1:0] clk_t, clk_c;

  int n_chk = 0, n_bad = 0;
  int edges = 0;
  int quiet = 0;
  bit scen_r9 = 1'b0;
  bit done = 1'b0;
  logic         last_halt = 1'b1;
  logic [N-1:0] last_mask = '0;
  logic [N-1:0] last_t = '0;
  int           run_len [N];

  always #2.5 clk = ~clk;

  clkstop_gate #(.N_OUT(N), .HALF(HALF), .DIFF_MAP(DMAP)) u0 (
    .clk(clk), .rst_n(rst_n), .halt_req_n(halt_req_n),
    .stoppable(stoppable), .clk_t(clk_t), .clk_c(clk_c)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      check(clk_t == '0, "R1 clk_t in reset", clk_t, 0);
      check(clk_c == DMAP, "R1 clk_c in reset", clk_c, DMAP);
    end else begin
      if (halt_req_n != last_halt || stoppable != last_mask) quiet = 1;
      else quiet++;
      last_halt = halt_req_n;
      last_mask = stoppable;
      for (int i = 0; i < N; i++) begin
        logic ref_lvl, park, stop_now;
        ref_lvl  = ((edges / HALF) % 2) != 0;
        park     = DMAP[i];
        stop_now = !halt_req_n && stoppable[i];
        if (DMAP[i]) check(clk_c[i] == ~clk_t[i], "R2 diff complement", clk_c[i], ~clk_t[i]);
        else         check(clk_c[i] == 1'b0, "R5 single-ended complement", clk_c[i], 0);
        if (clk_t[i] != last_t[i]) begin
          check(run_len[i] >= HALF, "R6 pulse width", run_len[i], HALF);
          run_len[i] = 1;
        end else run_len[i]++;
        last_t[i] = clk_t[i];
        if (clk_t[i] != ref_lvl)
          check(clk_t[i] == park, DMAP[i] ? "R4 diff park level" : "R5 se park level", clk_t[i], park);
        if (quiet >= LAT) begin
          if (stop_now)
            check(clk_t[i] == park, scen_r9 ? "R9 mask capture" : "R7 settled stop", clk_t[i], park);
          else if (!stoppable[i])
            check(clk_t[i] == ref_lvl, "R3 non-stoppable runs", clk_t[i], ref_lvl);
          else
            check(clk_t[i] == ref_lvl, scen_r9 ? "R9 mask release" : "R8 restart aligned", clk_t[i], ref_lvl);
        end else if (!stoppable[i] && halt_req_n == last_halt) begin
          check(clk_t[i] == ref_lvl || !halt_req_n == 1'b0 || clk_t[i] == park,
                "R2 running lane", clk_t[i], ref_lvl);
        end
      end
    end
  end

  task automatic drive(input logic h, input logic [N-1:0] m);
    @(negedge clk); #0.5;
    halt_req_n = h;
    stoppable  = m;
  endtask

  task automatic idle(input int c);
    repeat (c) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) run_len[i] = HALF;
    idle(4);
    @(negedge clk); #0.5;
    rst_n = 1'b1;
    idle(12);
    for (int m = 0; m < 16; m++) begin
      for (int off = 0; off < 2 * HALF; off++) begin
        drive(1'b1, 4'(m));
        idle(off + 1);
        drive(1'b0, 4'(m));
        idle(LAT + 4);
        drive(1'b1, 4'(m));
        idle(LAT + 4);
      end
    end
    scen_r9 = 1'b1;
    drive(1'b0, 4'b0000);
    idle(LAT + 2);
    for (int m = 0; m < 16; m++) begin
      drive(1'b0, 4'(m ^ (m >> 1)));
      idle(LAT + 3);
    end
    drive(1'b1, 4'b1111);
    idle(LAT + 4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule